// File: doc/BRIEF.md
# Transmit Flow-Control Credit Tracker

This block sits beside a transmit path and keeps its own record of how many flow-control credits have been spent in each of six traffic classes: posted, non-posted and completion traffic, each with a header class and a data class. The core that sends packets reports each spent credit as a one-cycle pulse on a six-bit vector. The tracker counts these pulses. It holds its own consumed totals and never reads them back from the core.

Each cycle the tracker subtracts the consumed totals from the limits it is given, modulo the counter width. When a packet waits to be sent, the requester presents the packet's class and its payload length in bytes. The tracker answers with a grant that shows whether one header credit and enough data credits are on hand. One data credit covers 16 bytes of payload. A class flagged as unlimited skips its check. A consumption pattern that cannot happen on a correct link sets a sticky error flag, and the tracker does not count that pattern.

Top module: `txfc_credit_tracker`

## Requirements
- R1: While `rst` is high at a clock edge, every consumed count and the error flag are cleared. Two edges after reset is released, the availability of every class equals its limit.
- R2: The consumption bits map to classes as follows: bit 5 posted header, bit 4 posted data, bit 3 non-posted header, bit 2 non-posted data, bit 1 completion header, bit 0 completion data. A pulse lowers the availability of its own class only.
- R3: A cycle with exactly one header bit set, together with the data bit of that same class, is legal. Both credits are counted.
- R4: A request needs ceil(length/16) data credits. A zero-length request needs no data credit.
- R5: With `req_valid` high and a defined class, `grant` is high when the class's header availability is at least 1 and its data availability is at least the data need.
- R6: Availability equals (limit − consumed) modulo 2^width. Header counters are `HDR_W` bits wide and data counters are `DAT_W` bits wide, so a counter that passes the limit wraps.
- R7: When the `inf_flag` bit of a class is set (same bit order as R2), the check for that class passes in the same cycle. This holds for the header part and the data part independently.
- R8: A change on a limit input affects `grant` only after the next clock edge.
- R9: Some consumption patterns are illegal: two or more header bits set together, a data bit without a header bit, or a data bit whose class differs from the header bit's class. Such a pattern changes no count. It sets `cons_err` on the next edge, and `cons_err` stays high until reset.
- R10: `grant` is low while `req_valid` is low, and it is low for the reserved class code 3. The class codes are 2 posted, 1 non-posted and 0 completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cons_pulse | input | 6 | One-cycle credit consumption pulses, mapped as in R2 |
| inf_flag | input | 6 | Unlimited-credit flags, mapped as in R2 |
| hdr_lim_p | input | HDR_W | Posted header credit limit |
| hdr_lim_np | input | HDR_W | Non-posted header credit limit |
| hdr_lim_cpl | input | HDR_W | Completion header credit limit |
| dat_lim_p | input | DAT_W | Posted data credit limit |
| dat_lim_np | input | DAT_W | Non-posted data credit limit |
| dat_lim_cpl | input | DAT_W | Completion data credit limit |
| req_valid | input | 1 | A packet is waiting for a send decision |
| req_class | input | 2 | Packet class: 2 posted, 1 non-posted, 0 completion, 3 reserved |
| req_len | input | LEN_W | Payload length in bytes |
| grant | output | 1 | Enough credit is available to send the packet |
| cons_err | output | 1 | Sticky flag for an illegal consumption pattern |

## Verification
The bench builds the tracker with `HDR_W` = 4, `DAT_W` = 6 and `LEN_W` = 10, and leaves the grant combinational. With a 4-bit header counter, sixteen header pulses wrap the counter, so the modular subtraction can be tested with a short run. A 6-bit data field caps availability at 63 credits, so a 1023-byte request, which needs 64 credits, goes past any data limit. That request shows that a data-side unlimited flag is the only thing that can grant it.

// File: rtl/txfc_pkg.sv
`timescale 1ns/1ps
package txfc_pkg;
   // Class index used by the per-class slots and by req_class.
   // Header bit of class k is 2k+1, data bit is 2k.
   typedef enum logic [1:0] {
      FC_CPL  = 2'd0,
      FC_NP   = 2'd1,
      FC_P    = 2'd2,
      FC_RSVD = 2'd3
   } fc_class_e;

   localparam int unsigned NUM_CLASS = 3;
   localparam int unsigned NUM_BITS  = 2 * NUM_CLASS;

   function automatic int unsigned hdr_bit(input int unsigned k);
      return 2 * k + 1;
   endfunction

   function automatic int unsigned dat_bit(input int unsigned k);
      return 2 * k;
   endfunction
endpackage

// File: rtl/txfc_cons_decode.sv
`timescale 1ns/1ps
// Splits the pulse vector into header and data lanes and screens
// out combinations that a correct link never produces.
module txfc_cons_decode
   import txfc_pkg::*;
(
   input  logic [NUM_BITS-1:0]  pulse,
   output logic [NUM_CLASS-1:0] hdr_inc,
   output logic [NUM_CLASS-1:0] dat_inc,
   output logic                 illegal
);
   logic [NUM_CLASS-1:0] hdr_raw;
   logic [NUM_CLASS-1:0] dat_raw;
   logic                 legal;

   for (genvar k = 0; k < NUM_CLASS; k++) begin : g_lane
      assign hdr_raw[k] = pulse[hdr_bit(k)];
      assign dat_raw[k] = pulse[dat_bit(k)];
   end

   always_comb begin
      if (hdr_raw == '0)
         legal = (dat_raw == '0);
      else
         legal = $onehot(hdr_raw) && ((dat_raw == '0) || (dat_raw == hdr_raw));
   end

   assign illegal = ~legal;
   assign hdr_inc = legal ? hdr_raw : '0;
   assign dat_inc = legal ? dat_raw : '0;
endmodule

// File: rtl/txfc_credit_slot.sv
`timescale 1ns/1ps
// One credit class: a wrapping consumed counter and a registered
// modular availability derived from the incoming limit.
module txfc_credit_slot #(
   parameter int unsigned W = 8
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         inc,
   input  logic [W-1:0] limit,
   output logic [W-1:0] avail
);
   logic [W-1:0] used_q;
   logic [W-1:0] avail_q;

   if (W < 1) begin : g_bad_w
      $error("txfc_credit_slot: W must be at least 1");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         used_q  <= '0;
         avail_q <= '0;
      end else begin
         used_q  <= used_q + W'(inc);
         avail_q <= limit - used_q;
      end
   end

   assign avail = avail_q;
endmodule

// File: rtl/txfc_grant_eval.sv
`timescale 1ns/1ps
// Picks the requested class, converts bytes to data credits and
// decides whether the packet may go.
module txfc_grant_eval
   import txfc_pkg::*;
#(
   parameter int unsigned HDR_W     = 8,
   parameter int unsigned DAT_W     = 12,
   parameter int unsigned LEN_W     = 13,
   parameter int unsigned DAT_BYTES = 16
) (
   input  logic [NUM_CLASS-1:0][HDR_W-1:0] hdr_avail,
   input  logic [NUM_CLASS-1:0][DAT_W-1:0] dat_avail,
   input  logic [NUM_BITS-1:0]             inf_flag,
   input  logic                            req_valid,
   input  logic [1:0]                      req_class,
   input  logic [LEN_W-1:0]                req_len,
   output logic                            ok
);
   localparam int unsigned SH     = $clog2(DAT_BYTES);
   localparam int unsigned NEED_W = LEN_W - SH + 1;
   localparam int unsigned CMP_W  = (NEED_W > DAT_W) ? NEED_W : DAT_W;

   logic [LEN_W:0]      len_x;
   logic [NEED_W-1:0]   need;
   logic [HDR_W-1:0]    hav;
   logic [DAT_W-1:0]    dav;
   logic                hinf;
   logic                dinf;
   logic                cls_ok;
   logic                hdr_ok;
   logic                dat_ok;
   logic [CMP_W-1:0]    dav_x;
   logic [CMP_W-1:0]    need_x;

   assign len_x = {1'b0, req_len} + (LEN_W+1)'(DAT_BYTES - 1);
   assign need  = len_x[LEN_W:SH];

   always_comb begin
      cls_ok = (req_class != FC_RSVD);
      hav    = '0;
      dav    = '0;
      hinf   = 1'b0;
      dinf   = 1'b0;
      for (int k = 0; k < NUM_CLASS; k++) begin
         if (req_class == 2'(k)) begin
            hav  = hdr_avail[k];
            dav  = dat_avail[k];
            hinf = inf_flag[hdr_bit(k)];
            dinf = inf_flag[dat_bit(k)];
         end
      end
   end

   assign dav_x  = CMP_W'(dav);
   assign need_x = CMP_W'(need);
   assign hdr_ok = hinf || (hav != '0);
   assign dat_ok = dinf || (dav_x >= need_x);
   assign ok     = req_valid && cls_ok && hdr_ok && dat_ok;
endmodule

// File: rtl/txfc_credit_tracker.sv
`timescale 1ns/1ps
module txfc_credit_tracker
   import txfc_pkg::*;
#(
   parameter int unsigned HDR_W     = 8,
   parameter int unsigned DAT_W     = 12,
   parameter int unsigned LEN_W     = 13,
   parameter int unsigned DAT_BYTES = 16,
   parameter bit          GRANT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [5:0]       cons_pulse,
   input  logic [5:0]       inf_flag,
   input  logic [HDR_W-1:0] hdr_lim_p,
   input  logic [HDR_W-1:0] hdr_lim_np,
   input  logic [HDR_W-1:0] hdr_lim_cpl,
   input  logic [DAT_W-1:0] dat_lim_p,
   input  logic [DAT_W-1:0] dat_lim_np,
   input  logic [DAT_W-1:0] dat_lim_cpl,
   input  logic             req_valid,
   input  logic [1:0]       req_class,
   input  logic [LEN_W-1:0] req_len,
   output logic             grant,
   output logic             cons_err
);
   localparam int unsigned SH = $clog2(DAT_BYTES);

   if (HDR_W < 1 || DAT_W < 1) begin : g_bad_width
      $error("txfc_credit_tracker: counter widths must be positive");
   end
   if ((1 << SH) != DAT_BYTES) begin : g_bad_bytes
      $error("txfc_credit_tracker: DAT_BYTES must be a power of two");
   end
   if (LEN_W <= SH) begin : g_bad_len
      $error("txfc_credit_tracker: LEN_W must exceed log2(DAT_BYTES)");
   end

   logic [NUM_CLASS-1:0][HDR_W-1:0] hdr_lim;
   logic [NUM_CLASS-1:0][DAT_W-1:0] dat_lim;
   logic [NUM_CLASS-1:0][HDR_W-1:0] hdr_avail;
   logic [NUM_CLASS-1:0][DAT_W-1:0] dat_avail;
   logic [NUM_CLASS-1:0]            hdr_inc;
   logic [NUM_CLASS-1:0]            dat_inc;
   logic                            bad_pat;
   logic                            err_q;
   logic                            ok;

   assign hdr_lim[FC_CPL] = hdr_lim_cpl;
   assign hdr_lim[FC_NP]  = hdr_lim_np;
   assign hdr_lim[FC_P]   = hdr_lim_p;
   assign dat_lim[FC_CPL] = dat_lim_cpl;
   assign dat_lim[FC_NP]  = dat_lim_np;
   assign dat_lim[FC_P]   = dat_lim_p;

   txfc_cons_decode u_dec (
      .pulse   (cons_pulse),
      .hdr_inc (hdr_inc),
      .dat_inc (dat_inc),
      .illegal (bad_pat)
   );

   for (genvar k = 0; k < NUM_CLASS; k++) begin : g_cls
      txfc_credit_slot #(.W(HDR_W)) u_hdr (
         .clk   (clk),
         .rst   (rst),
         .inc   (hdr_inc[k]),
         .limit (hdr_lim[k]),
         .avail (hdr_avail[k])
      );
      txfc_credit_slot #(.W(DAT_W)) u_dat (
         .clk   (clk),
         .rst   (rst),
         .inc   (dat_inc[k]),
         .limit (dat_lim[k]),
         .avail (dat_avail[k])
      );
   end

   txfc_grant_eval #(
      .HDR_W     (HDR_W),
      .DAT_W     (DAT_W),
      .LEN_W     (LEN_W),
      .DAT_BYTES (DAT_BYTES)
   ) u_eval (
      .hdr_avail (hdr_avail),
      .dat_avail (dat_avail),
      .inf_flag  (inf_flag),
      .req_valid (req_valid),
      .req_class (req_class),
      .req_len   (req_len),
      .ok        (ok)
   );

   always_ff @(posedge clk) begin
      if (rst) err_q <= 1'b0;
      else     err_q <= err_q | bad_pat;
   end
   assign cons_err = err_q;

   if (GRANT_REG) begin : g_grant_ff
      logic grant_q;
      always_ff @(posedge clk) begin
         if (rst) grant_q <= 1'b0;
         else     grant_q <= ok;
      end
      assign grant = grant_q;
   end else begin : g_grant_comb
      assign grant = ok;
   end
endmodule

// File: rtl/txfc_chk.sv
`timescale 1ns/1ps
module txfc_chk #(
   parameter bit GRANT_REG = 1'b0
) (
   input logic       clk,
   input logic       rst,
   input logic [5:0] cons_pulse,
   input logic [5:0] inf_flag,
   input logic       req_valid,
   input logic [1:0] req_class,
   input logic       grant,
   input logic       cons_err
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> !cons_err);

   // R9
   err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
      cons_err |=> cons_err);

   // R9
   dbl_hdr_err_chk: assert property (@(posedge clk) disable iff (rst)
      ($countones({cons_pulse[5], cons_pulse[3], cons_pulse[1]}) > 1) |=> cons_err);

   // R9
   orphan_data_chk: assert property (@(posedge clk) disable iff (rst)
      ((cons_pulse[4] && !cons_pulse[5]) || (cons_pulse[2] && !cons_pulse[3]) ||
       (cons_pulse[0] && !cons_pulse[1])) |=> cons_err);

   if (GRANT_REG) begin : g_seq
      // R10
      idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
         !req_valid |=> !grant);
      // R10
      rsvd_class_chk: assert property (@(posedge clk) disable iff (rst)
         (req_valid && req_class == 2'd3) |=> !grant);
      // R7
      inf_bypass_chk: assert property (@(posedge clk) disable iff (rst)
         (req_valid && req_class == 2'd2 && inf_flag[5] && inf_flag[4]) |=> grant);
   end else begin : g_comb
      // R10
      idle_no_grant_chk: assert property (@(posedge clk) disable iff (rst)
         !req_valid |-> !grant);
      // R10
      rsvd_class_chk: assert property (@(posedge clk) disable iff (rst)
         (req_valid && req_class == 2'd3) |-> !grant);
      // R7
      inf_bypass_chk: assert property (@(posedge clk) disable iff (rst)
         (req_valid && req_class == 2'd2 && inf_flag[5] && inf_flag[4]) |-> grant);
   end
endmodule

bind txfc_credit_tracker txfc_chk #(.GRANT_REG(GRANT_REG)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cons_pulse (cons_pulse),
   .inf_flag   (inf_flag),
   .req_valid  (req_valid),
   .req_class  (req_class),
   .grant      (grant),
   .cons_err   (cons_err)
);

// File: tb/sim_txfc_credit_tracker.sv
`timescale 1ns/1ps
module sim_txfc_credit_tracker;
   localparam int unsigned HW = 4;
   localparam int unsigned DW = 6;
   localparam int unsigned LW = 10;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [5:0]    cons_pulse = '0;
   logic [5:0]    inf_flag = '0;
   logic [HW-1:0] hdr_lim_p = '0, hdr_lim_np = '0, hdr_lim_cpl = '0;
   logic [DW-1:0] dat_lim_p = '0, dat_lim_np = '0, dat_lim_cpl = '0;
   logic          req_valid = 1'b0;
   logic [1:0]    req_class = '0;
   logic [LW-1:0] req_len = '0;
   logic          grant;
   logic          cons_err;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk; // 50 MHz

   txfc_credit_tracker #(.HDR_W(HW), .DAT_W(DW), .LEN_W(LW)) u0 (
      .clk(clk), .rst(rst), .cons_pulse(cons_pulse), .inf_flag(inf_flag),
      .hdr_lim_p(hdr_lim_p), .hdr_lim_np(hdr_lim_np), .hdr_lim_cpl(hdr_lim_cpl),
      .dat_lim_p(dat_lim_p), .dat_lim_np(dat_lim_np), .dat_lim_cpl(dat_lim_cpl),
      .req_valid(req_valid), .req_class(req_class), .req_len(req_len),
      .grant(grant), .cons_err(cons_err)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic check(input logic act, input logic exp, input string req);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic ask(input logic [1:0] c, input int len, input logic exp, input string req);
      req_valid = 1'b1;
      req_class = c;
      req_len   = LW'(len);
      #1;
      check(grant, exp, req);
   endtask

   task automatic pulse(input logic [5:0] v);
      cons_pulse = v;
      tick();
      cons_pulse = '0;
      tick();
   endtask

   // Reset with every class at 3 header and 5 data credits.
   task automatic restart();
      inf_flag  = '0;
      req_valid = 1'b0;
      hdr_lim_p = 3; hdr_lim_np = 3; hdr_lim_cpl = 3;
      dat_lim_p = 5; dat_lim_np = 5; dat_lim_cpl = 5;
      rst = 1'b1;
      tick(); tick();
      rst = 1'b0;
      tick(); tick();
   endtask

   task automatic t_reset();
      restart();
      check(cons_err, 1'b0, "R1 error clear after reset");
      ask(2, 80, 1'b1, "R1 R5 posted 80 bytes fits limit");
      ask(2, 81, 1'b0, "R5 posted 81 bytes needs 6 credits");
   endtask

   task automatic t_need();
      restart();
      dat_lim_np = 0;
      tick();
      ask(1, 0, 1'b1, "R4 zero length needs no data");
      ask(1, 1, 1'b0, "R4 one byte needs one credit");
      dat_lim_np = 1;
      tick();
      ask(1, 16, 1'b1, "R4 16 bytes needs one credit");
      ask(1, 17, 1'b0, "R4 17 bytes needs two credits");
   endtask

   task automatic t_map();
      restart();
      for (int i = 0; i < 3; i++) pulse(6'b100000);
      ask(2, 0, 1'b0, "R2 posted header exhausted");
      ask(1, 0, 1'b1, "R2 non-posted untouched");
      ask(0, 0, 1'b1, "R2 completion untouched");
   endtask

   task automatic t_pair();
      restart();
      pulse(6'b001100);
      ask(1, 64, 1'b1, "R3 non-posted 4 data left");
      ask(1, 65, 1'b0, "R3 non-posted pair counted");
      pulse(6'b000011);
      pulse(6'b000011);
      ask(0, 48, 1'b1, "R3 completion 3 data left");
      ask(0, 49, 1'b0, "R3 completion pairs counted");
      ask(2, 80, 1'b1, "R2 posted untouched by pairs");
      check(cons_err, 1'b0, "R3 legal pairs raise no error");
   endtask

   task automatic t_wrap();
      restart();
      for (int i = 0; i < 3; i++) pulse(6'b100000);
      ask(2, 0, 1'b0, "R6 availability zero at limit");
      pulse(6'b100000);
      ask(2, 0, 1'b1, "R6 availability wraps to 15");
      for (int i = 0; i < 12; i++) pulse(6'b100000);
      ask(2, 0, 1'b1, "R6 counter wrapped to zero");
      hdr_lim_p = 0;
      tick();
      ask(2, 0, 1'b0, "R6 zero limit minus wrapped count");
   endtask

   task automatic t_limit();
      restart();
      ask(0, 80, 1'b1, "R8 completion 5 credits before change");
      dat_lim_cpl = 4;
      #1;
      check(grant, 1'b1, "R8 old limit holds before edge");
      tick();
      check(grant, 1'b0, "R8 new limit after edge");
   endtask

   task automatic t_inf();
      restart();
      hdr_lim_p = 0;
      tick();
      ask(2, 0, 1'b0, "R7 posted header empty");
      inf_flag = 6'b100000;
      ask(2, 0, 1'b1, "R7 header flag bypasses");
      ask(2, 1023, 1'b0, "R7 data still limited");
      inf_flag = 6'b110000;
      ask(2, 1023, 1'b1, "R7 data flag bypasses");
      ask(1, 1023, 1'b0, "R7 flags of other class ignored");
   endtask

   task automatic t_illegal();
      restart();
      pulse(6'b000100);
      check(cons_err, 1'b1, "R9 data without header flags error");
      ask(1, 80, 1'b1, "R9 orphan data not counted");
      for (int i = 0; i < 3; i++) pulse(6'b101000);
      ask(2, 0, 1'b1, "R9 double header not counted");
      pulse(6'b100001);
      ask(0, 80, 1'b1, "R9 mismatched pair not counted");
      req_valid = 1'b0;
      tick(); tick();
      check(cons_err, 1'b1, "R9 error stays set");
      rst = 1'b1;
      tick();
      rst = 1'b0;
      check(cons_err, 1'b0, "R1 R9 reset clears error");
   endtask

   task automatic t_resv();
      restart();
      inf_flag = 6'b111111;
      ask(3, 0, 1'b0, "R10 reserved class never granted");
      req_valid = 1'b0;
      req_class = 2;
      #1;
      check(grant, 1'b0, "R10 no grant without request");
   endtask

   initial begin
      t_reset();
      t_need();
      t_map();
      t_pair();
      t_wrap();
      t_limit();
      t_inf();
      t_illegal();
      t_resv();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      #2000000;
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end
endmodule